// File: doc/BRIEF.md
# Memory-to-Memory Three-Stage Processor Core

This block is a small multi-cycle processor with no register file. Every operand lives in an internal byte-addressed RAM of 256 bytes. Each instruction takes four clock cycles. The first cycle fetches a 4-byte instruction word at the program counter. The next three cycles do the following:
- Stage 1 obtains a "source" value from RAM, from one of sixteen 32-bit input ports, or from an immediate byte.
- Stage 2 obtains a "target" value from RAM, either directly or through a pointer taken from the stage-1 value.
- Stage 3 passes both values through the ALU and sends the result to one place: RAM, an output port, the program counter, or nowhere.

A byte-wide load port fills the RAM before the core is released from reset. A combinational byte peek port lets the surrounding logic inspect the RAM image. A one-cycle retire pulse marks the end of every instruction, so an external model can be stepped in lock-step with the core. Output port writes appear as a one-cycle strobe that carries the port index and the data.

Top module: `mmc_core`

## Requirements
- R1: While rst_ni is low and after its release, pc_o reads 0x40, zero_o reads 0, and retire_o and out_we_o read 0 until the first instruction retires.
- R2: The instruction word is the little-endian 32-bit word read at pc_o. Its fields are: bits 2:0 ALU op, bits 4:3 source selector, bit 5 target selector, bits 8:6 result selector, bits 23:16 source operand byte, bits 31:24 target operand byte. Bits 15:9 are ignored.
- R3: The source selector picks the source value. Codes 0 and 1 read the RAM word at the source operand byte. Code 2 reads the input port indexed by the low 4 bits of the source operand. Code 3 uses the source operand byte zero-extended. The input port is sampled once, in stage 1.
- R4: The target selector picks the target value. Code 0 reads the RAM word at the target operand byte. Code 1 reads the RAM word at the low 8 bits of the source value.
- R5: The ALU computes target OP source, truncated to 32 bits. Op codes: 0 add, 1 target minus source, 2 target shifted left by source, 3 target shifted right (logical) by source, 4 source, 5 target, 6 AND, 7 OR. A shift by 32 or more gives 0.
- R6: The result selector picks where the result goes. Code 0 writes nothing. Code 1 writes the RAM word at the target operand byte. Code 2 writes an output port. Code 3 writes the RAM word at the low 8 bits of the target value. Code 4 jumps. Code 5 jumps only when the zero flag is set. Codes 6 and 7 write nothing.
- R7: pc_o advances by 4, wrapping modulo 256, unless a jump loads it with the low 8 bits of the result.
- R8: zero_o is set after every instruction exactly when the 32-bit result is 0. A conditional jump tests the value zero_o held before that instruction.
- R9: A RAM word access touches 4 consecutive bytes, least significant byte first, with addresses wrapping modulo 256.
- R10: An output port write raises out_we_o for exactly one cycle, in the retire cycle. out_sel_o is the low 4 bits of the target operand and out_data_o is the result.
- R11: Instructions retire exactly 4 cycles apart. retire_o is a one-cycle pulse. pc_o and zero_o change only in the cycle retire_o rises.
- R12: A load write stores load_data_i at load_addr_i on the clock edge. A core RAM write to the same byte in the same cycle takes priority. peek_data_o shows the RAM byte at peek_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_we_i | input | 1 | RAM load byte write enable |
| load_addr_i | input | 8 | RAM load byte address |
| load_data_i | input | 8 | RAM load byte data |
| peek_addr_i | input | 8 | RAM inspection byte address |
| peek_data_o | output | 8 | RAM byte at peek_addr_i |
| in_data_i | input | 512 | Sixteen 32-bit input ports, port k at bits 32k+31:32k |
| out_we_o | output | 1 | One-cycle output port write strobe |
| out_sel_o | output | 4 | Output port index |
| out_data_o | output | 32 | Output port data |
| pc_o | output | 8 | Program counter |
| zero_o | output | 1 | Zero flag from the last retired instruction |
| retire_o | output | 1 | One-cycle pulse per retired instruction |

## Verification
The hardest situations to reach from the ports need a particular sequence of instructions:
- a conditional jump whose flag was set by the previous instruction;
- a pointer read or write whose address comes from a value computed earlier;
- a word access that straddles the top of the RAM.

A directed program at 0x40 builds each of these in order. Its explicit expected values are checked at each retire pulse. A second run fills the whole RAM with random bytes, so random opcodes, jumps and self-modifying stores occur. That run steps a bench reference model at every retirement and then compares the full RAM image through the peek port.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int AW        = 8;   // operand byte addresses the whole RAM
  localparam int DW        = 32;
  localparam int WORD_B    = DW / 8;
  localparam int RAM_DEPTH = 1 << AW;

  typedef enum logic [1:0] {ST_FETCH, ST_SRC, ST_TGT, ST_RES} state_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_SHL = 3'd2, OP_SHR = 3'd3,
    OP_SRC = 3'd4, OP_TGT = 3'd5, OP_AND = 3'd6, OP_OR  = 3'd7
  } alu_op_e;

  localparam logic [1:0] SRC_PORT  = 2'd2;
  localparam logic [1:0] SRC_IMM   = 2'd3;

  localparam logic [2:0] RES_NONE  = 3'd0;
  localparam logic [2:0] RES_MEM   = 3'd1;
  localparam logic [2:0] RES_PORT  = 3'd2;
  localparam logic [2:0] RES_IND   = 3'd3;
  localparam logic [2:0] RES_JMP   = 3'd4;
  localparam logic [2:0] RES_JZ    = 3'd5;
endpackage

// File: rtl/mmc_seq.sv
module mmc_seq
  import mmc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output state_e state_o
);
  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_SRC;
        ST_SRC:   state_q <= ST_TGT;
        ST_TGT:   state_q <= ST_RES;
        default:  state_q <= ST_FETCH;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mmc_ram.sv
module mmc_ram #(
  parameter int AW     = 8,
  parameter int WORD_B = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [8*WORD_B-1:0] rd_word_o,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [8*WORD_B-1:0] wr_word_i,
  input  logic                ld_en_i,
  input  logic [AW-1:0]       ld_addr_i,
  input  logic [7:0]          ld_data_i,
  input  logic [AW-1:0]       pk_addr_i,
  output logic [7:0]          pk_data_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ra [WORD_B];
  logic [AW-1:0] wa [WORD_B];

  // per-lane addresses, wrapping at the AW-bit boundary
  for (genvar i = 0; i < WORD_B; i++) begin : g_lane
    assign ra[i] = rd_addr_i + AW'(i);
    assign wa[i] = wr_addr_i + AW'(i);
    assign rd_word_o[8*i +: 8] = mem[ra[i]];
  end

  // core write lanes follow the load write, so they win on a collision
  always_ff @(posedge clk_i) begin
    if (ld_en_i) mem[ld_addr_i] <= ld_data_i;
    if (wr_en_i) begin
      for (int i = 0; i < WORD_B; i++) mem[wa[i]] <= wr_word_i[8*i +: 8];
    end
  end

  assign pk_data_o = mem[pk_addr_i];
endmodule

// File: rtl/mmc_alu.sv
module mmc_alu
  import mmc_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] tgt_i,  // left operand
  input  logic [W-1:0] src_i,
  output logic [W-1:0] res_o
);
  logic big_shift;
  assign big_shift = |src_i[W-1:SW];

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_ADD: res_o = tgt_i + src_i;
      OP_SUB: res_o = tgt_i - src_i;
      OP_SHL: res_o = big_shift ? '0 : tgt_i << src_i[SW-1:0];
      OP_SHR: res_o = big_shift ? '0 : tgt_i >> src_i[SW-1:0];
      OP_SRC: res_o = src_i;
      OP_TGT: res_o = tgt_i;
      OP_AND: res_o = tgt_i & src_i;
      default: res_o = tgt_i | src_i;
    endcase
  end
endmodule

// File: rtl/mmc_core.sv
module mmc_core
  import mmc_pkg::*;
#(
  parameter int          N_PORTS  = 16,
  parameter logic [7:0]  PC_RESET = 8'h40,
  localparam int         PW       = $clog2(N_PORTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_we_i,
  input  logic [AW-1:0]         load_addr_i,
  input  logic [7:0]            load_data_i,
  input  logic [AW-1:0]         peek_addr_i,
  output logic [7:0]            peek_data_o,
  input  logic [N_PORTS*DW-1:0] in_data_i,
  output logic                  out_we_o,
  output logic [PW-1:0]         out_sel_o,
  output logic [DW-1:0]         out_data_o,
  output logic [AW-1:0]         pc_o,
  output logic                  zero_o,
  output logic                  retire_o
);
  state_e        state;
  logic [AW-1:0] pc_q;
  logic          zf_q;
  logic [2:0]    f_alu, f_res;
  logic [1:0]    f_src;
  logic          f_tgt;
  logic [7:0]    f_sop, f_top;
  logic [DW-1:0] src_q, tgt_q;
  logic          retire_q, owe_q;
  logic [PW-1:0] osel_q;
  logic [DW-1:0] odata_q;

  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] in_sel;
  logic [DW-1:0] src_next;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic          take_jump;
  logic          unused_bits;

  assign unused_bits = ^{rd_word[15:9], f_sop[7:PW], f_top[7:PW]};

  mmc_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (state)
  );

  always_comb begin
    unique case (state)
      ST_SRC:  rd_addr = f_sop;
      ST_TGT:  rd_addr = f_tgt ? src_q[AW-1:0] : f_top;
      default: rd_addr = pc_q;
    endcase
  end

  assign mem_we = (state == ST_RES) && (f_res == RES_MEM || f_res == RES_IND);
  assign mem_wa = (f_res == RES_IND) ? tgt_q[AW-1:0] : f_top;

  mmc_ram #(.AW(AW), .WORD_B(WORD_B)) u_ram (
    .clk_i     (clk_i),
    .rd_addr_i (rd_addr),
    .rd_word_o (rd_word),
    .wr_en_i   (mem_we),
    .wr_addr_i (mem_wa),
    .wr_word_i (alu_res),
    .ld_en_i   (load_we_i),
    .ld_addr_i (load_addr_i),
    .ld_data_i (load_data_i),
    .pk_addr_i (peek_addr_i),
    .pk_data_o (peek_data_o)
  );

  mmc_alu #(.W(DW)) u_alu (
    .op_i  (f_alu),
    .tgt_i (tgt_q),
    .src_i (src_q),
    .res_o (alu_res)
  );

  assign in_sel = in_data_i[f_sop[PW-1:0]*DW +: DW];

  always_comb begin
    unique case (f_src)
      SRC_PORT: src_next = in_sel;
      SRC_IMM:  src_next = {{(DW-8){1'b0}}, f_sop};
      default:  src_next = rd_word;
    endcase
  end

  assign take_jump = (f_res == RES_JMP) || (f_res == RES_JZ && zf_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_alu <= '0; f_src <= '0; f_tgt <= 1'b0; f_res <= '0;
      f_sop <= '0; f_top <= '0;
    end else if (state == ST_FETCH) begin
      f_alu <= rd_word[2:0];
      f_src <= rd_word[4:3];
      f_tgt <= rd_word[5];
      f_res <= rd_word[8:6];
      f_sop <= rd_word[23:16];
      f_top <= rd_word[31:24];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      tgt_q <= '0;
    end else begin
      if (state == ST_SRC) src_q <= src_next;
      if (state == ST_TGT) tgt_q <= rd_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= PC_RESET;
      zf_q     <= 1'b0;
      retire_q <= 1'b0;
      owe_q    <= 1'b0;
      osel_q   <= '0;
      odata_q  <= '0;
    end else begin
      retire_q <= (state == ST_RES);
      owe_q    <= (state == ST_RES) && (f_res == RES_PORT);
      if (state == ST_RES) begin
        pc_q <= take_jump ? alu_res[AW-1:0] : pc_q + AW'(WORD_B);
        zf_q <= (alu_res == '0);
        if (f_res == RES_PORT) begin
          osel_q  <= f_top[PW-1:0];
          odata_q <= alu_res;
        end
      end
    end
  end

  assign pc_o       = pc_q;
  assign zero_o     = zf_q;
  assign retire_o   = retire_q;
  assign out_we_o   = owe_q;
  assign out_sel_o  = osel_q;
  assign out_data_o = odata_q;
endmodule

// File: rtl/mmc_core_chk.sv
module mmc_core_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retire_o,
  input logic          out_we_o,
  input logic [AW-1:0] pc_o,
  input logic          zero_o
);
  // R10
  out_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> retire_o);

  // R11
  retire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);

  // R11
  retire_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retire_o) |-> !$past(retire_o, 2) && !$past(retire_o, 3));

  // R7
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |-> $rose(retire_o));

  // R8
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(zero_o) |-> $rose(retire_o));
endmodule

bind mmc_core mmc_core_chk #(.AW(mmc_pkg::AW)) u_chk (.*);

// File: tb/sim_mmc_core.sv
module sim_mmc_core;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_we_i = 1'b0;
  logic [7:0]   load_addr_i = '0;
  logic [7:0]   load_data_i = '0;
  logic [7:0]   peek_addr_i = '0;
  logic [7:0]   peek_data_o;
  logic [511:0] in_data_i = '0;
  logic         out_we_o;
  logic [3:0]   out_sel_o;
  logic [31:0]  out_data_o;
  logic [7:0]   pc_o;
  logic         zero_o;
  logic         retire_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mem_m [256];
  logic [7:0] pc_m;
  logic       zf_m;

  always #5 clk_i = ~clk_i;

  mmc_core u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(logic [7:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = mem_m[8'(a + 8'(i))];
    return w;
  endfunction

  task automatic wrw(logic [7:0] a, logic [31:0] w);
    for (int i = 0; i < 4; i++) mem_m[8'(a + 8'(i))] = w[8*i +: 8];
  endtask

  function automatic logic [31:0] enc(int op, int s, int t, int r, int sop, int top);
    return {8'(top), 8'(sop), 7'd0, 3'(r), 1'(t), 2'(s), 3'(op)};
  endfunction

  // reference step from the requirements
  task automatic model_step(output logic ow, output logic [3:0] oi, output logic [31:0] od);
    logic [31:0] ins, sv, tv, y;
    logic [7:0]  npc;
    ins = rdw(pc_m);
    case (ins[4:3])
      2'd3:    sv = {24'd0, ins[23:16]};
      2'd2:    sv = in_data_i[32*ins[19:16] +: 32];
      default: sv = rdw(ins[23:16]);
    endcase
    tv = ins[5] ? rdw(sv[7:0]) : rdw(ins[31:24]);
    case (ins[2:0])
      3'd0: y = tv + sv;
      3'd1: y = tv - sv;
      3'd2: y = (sv >= 32) ? 32'd0 : tv << sv;
      3'd3: y = (sv >= 32) ? 32'd0 : tv >> sv;
      3'd4: y = sv;
      3'd5: y = tv;
      3'd6: y = tv & sv;
      default: y = tv | sv;
    endcase
    npc = pc_m + 8'd4;
    ow = 1'b0; oi = '0; od = '0;
    case (ins[8:6])
      3'd1: wrw(ins[31:24], y);
      3'd2: begin ow = 1'b1; oi = ins[27:24]; od = y; end
      3'd3: wrw(tv[7:0], y);
      3'd4: npc = y[7:0];
      3'd5: if (zf_m) npc = y[7:0];
      default: ;
    endcase
    zf_m = (y == 0);
    pc_m = npc;
  endtask

  task automatic load_image(input logic [7:0] img [256]);
    rst_ni = 1'b0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk_i);
      load_we_i = 1'b1; load_addr_i = 8'(a); load_data_i = img[a];
      mem_m[a] = img[a];
    end
    @(negedge clk_i);
    load_we_i = 1'b0;
    pc_m = 8'h40; zf_m = 1'b0;
    // R1 reset state while held
    chk("R1 pc in reset", 32'(pc_o), 32'h40);
    chk("R1 zero in reset", 32'(zero_o), 0);
    chk("R1 retire in reset", 32'(retire_o), 0);
    peek_addr_i = 8'h40; #1;
    chk("R12 preload peek", 32'(peek_data_o), 32'(img[8'h40]));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pc after release", 32'(pc_o), 32'h40);
    chk("R1 no strobe after release", 32'(out_we_o), 0);
  endtask

  task automatic wait_retire(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!retire_o && cyc < 32);
    if (!retire_o) chk("R11 retire missing", 0, 1);
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    peek_addr_i = a; #1; d = peek_data_o;
  endtask

  logic [7:0] img [256];

  initial begin
    logic        ow;
    logic [3:0]  oi;
    logic [31:0] od;
    logic [7:0]  pb;
    logic [31:0] in3;
    int          cyc;
    void'($urandom(32'd7351));

    // directed program
    for (int a = 0; a < 256; a++) img[a] = 8'h00;
    in3 = 32'hA5C3_1E77;
    in_data_i[32*3 +: 32] = in3;
    begin
      logic [31:0] prog [13];
      logic [7:0]  at [13];
      prog[0]  = enc(4, 3, 0, 1, 5,    8'h10); at[0]  = 8'h40;
      prog[1]  = enc(4, 3, 0, 1, 8'h10, 8'h14); at[1] = 8'h44;
      prog[2]  = enc(5, 0, 1, 1, 8'h14, 8'h18); at[2] = 8'h48;
      prog[3]  = enc(2, 3, 0, 1, 40,   8'h18); at[3]  = 8'h4C;
      prog[4]  = enc(4, 3, 0, 5, 8'h60, 0);    at[4]  = 8'h50;
      prog[5]  = enc(4, 3, 0, 5, 8'h40, 0);    at[5]  = 8'h60;
      prog[6]  = enc(4, 2, 0, 1, 3,    8'h1C); at[6]  = 8'h64;
      prog[7]  = enc(4, 0, 0, 2, 8'h1C, 9);    at[7]  = 8'h68;
      prog[8]  = enc(4, 0, 0, 3, 8'h1C, 8'h14); at[8] = 8'h6C;
      prog[9]  = enc(1, 3, 0, 1, 1,    8'hFE); at[9]  = 8'h70;
      prog[10] = enc(0, 0, 0, 7, 8'h10, 8'h10); at[10] = 8'h74;
      prog[11] = enc(0, 1, 0, 1, 8'h1C, 8'h20); at[11] = 8'h78;
      prog[12] = enc(4, 3, 0, 4, 8'h7C, 0);    at[12] = 8'h7C;
      for (int k = 0; k < 13; k++)
        for (int b = 0; b < 4; b++) img[8'(at[k] + 8'(b))] = prog[k][8*b +: 8];
    end
    load_image(img);
    for (int k = 0; k < 15; k++) begin
      wait_retire(cyc);
      if (k > 0) chk("R11 retire spacing", 32'(cyc), 4);
      model_step(ow, oi, od);
      chk("R2 pc vs model", 32'(pc_o), 32'(pc_m));
      chk("R8 zero vs model", 32'(zero_o), 32'(zf_m));
      chk("R10 strobe vs model", 32'(out_we_o), 32'(ow));
      case (k)
        2:  begin peek(8'h18, pb); chk("R4 pointer read", 32'(pb), 5); end
        3:  begin peek(8'h18, pb); chk("R5 shift by 40", 32'(pb), 0);
                  chk("R8 zero set", 32'(zero_o), 1); end
        4:  chk("R8 taken jump", 32'(pc_o), 32'h60);
        5:  chk("R7 untaken jump", 32'(pc_o), 32'h64);
        7:  begin chk("R10 strobe", 32'(out_we_o), 1);
                  chk("R10 port idx", 32'(out_sel_o), 9);
                  chk("R3 input port data", out_data_o, in3); end
        8:  begin peek(8'h10, pb); chk("R6 indirect store", 32'(pb), 32'(in3[7:0])); end
        9:  begin peek(8'hFE, pb); chk("R9 wrap byte FE", 32'(pb), 32'hFF);
                  peek(8'h01, pb); chk("R9 wrap byte 01", 32'(pb), 32'hFF); end
        10: begin peek(8'h10, pb); chk("R6 code 7 no write", 32'(pb), 32'(in3[7:0])); end
        11: begin peek(8'h20, pb); chk("R3 code 1 RAM read", 32'(pb), 32'(in3[7:0])); end
        12: chk("R7 jump to self", 32'(pc_o), 32'h7C);
        default: ;
      endcase
      if (ow) begin
        chk("R10 idx vs model", 32'(out_sel_o), 32'(oi));
        chk("R10 data vs model", out_data_o, od);
      end
    end

    // random image, lock-step with the model
    for (int a = 0; a < 256; a++) img[a] = 8'($urandom);
    for (int p = 0; p < 16; p++) in_data_i[32*p +: 32] = $urandom;
    load_image(img);
    for (int k = 0; k < 600; k++) begin
      wait_retire(cyc);
      if (k > 0) chk("R11 retire spacing", 32'(cyc), 4);
      model_step(ow, oi, od);
      chk("R7 pc vs model", 32'(pc_o), 32'(pc_m));
      chk("R8 zero vs model", 32'(zero_o), 32'(zf_m));
      chk("R10 strobe vs model", 32'(out_we_o), 32'(ow));
      if (ow) begin
        chk("R10 idx vs model", 32'(out_sel_o), 32'(oi));
        chk("R10 data vs model", out_data_o, od);
      end
      in_data_i[32*($urandom % 16) +: 32] = ($urandom % 4 == 0) ? 32'd0 : $urandom;
    end
    for (int a = 0; a < 256; a++) begin
      peek(8'(a), pb);
      chk("R9 RAM image", 32'(pb), 32'(mem_m[a]));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule